// File: doc/BRIEF.md
# Binary64 to Wrapping Int32 Converter

This block turns an IEEE-754 double-precision operand into a 32-bit signed integer. It always truncates toward zero. When the value does not fit, the result is not clamped: the block returns the low 32 bits of the two's-complement integer. This is the conversion a script engine needs when it coerces a number to a 32-bit integer. Alongside the integer the block reports a single "exact" flag, placed in a 4-bit condition-code nibble. The flag is set only when the conversion lost nothing and stayed in range. Negative zero is deliberately reported as not exact.

A conversion starts when the input strobe is high for one cycle. One clock later the result, the condition nibble and an output strobe appear at the registered outputs. Three sticky exception flags (invalid, inexact, denormal input) collect events across conversions and return to zero only through a clear input. A mode input selects whether subnormal operands are flushed, in which case they are reported as denormal, or are treated as inexact.

Top module: `f64_modint32_cvt`

## Requirements
- R1: The operand is decoded as sign bit 63, exponent bits 62:52 and fraction bits 51:0. With a zero exponent and a zero fraction the result is 0 and no flag is raised. Z is 1 for +0.0 and 0 for -0.0.
- R2: With a zero exponent, a nonzero fraction and flush mode on, the result is 0, the denormal flag is raised, inexact is not raised, and Z equals the inverse of the sign.
- R3: With a zero exponent, a nonzero fraction and flush mode off, the result is 0, the inexact flag is raised, the denormal flag is not raised, and Z is 0.
- R4: An exponent of all ones (infinity or NaN, either sign) gives result 0, raises invalid and gives Z = 0.
- R5: For a normal operand whose truncated value fits in signed 32 bits, the result is the value truncated toward zero. If any fraction bits are dropped, inexact is raised and Z is 0. Otherwise Z is 1 and no flag is raised.
- R6: Overflow occurs when the unbiased exponent exceeds 31, or when the magnitude exceeds 2^31-1 for positive operands or 2^31 for negative ones. Overflow raises invalid (not inexact) and gives Z = 0. -2^31 is exact.
- R7: The result is always the low 32 bits of the signed truncated integer, also after overflow (for example 2^32+5 gives 5). The magnitude is 0 once the left shift reaches 64 or more, and once the right shift reaches 64 or more.
- R8: nzcv_o carries Z in bit 2. Bits 3, 1 and 0 are always 0.
- R9: out_valid_o is high exactly in the cycle after in_valid_i is high. result_o and nzcv_o change only at that edge and otherwise hold their values.
- R10: The exception flags are sticky. A cycle with clr_flags_i high discards the flags collected earlier, but events from a conversion accepted in that same cycle are still recorded.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand strobe |
| operand_i | input | 64 | Binary64 operand |
| flush_den_i | input | 1 | 1 = subnormal operands are flushed and reported as denormal |
| clr_flags_i | input | 1 | Clears the sticky exception flags |
| out_valid_o | output | 1 | Result strobe, one cycle after in_valid_i |
| result_o | output | 32 | Wrapped, truncated integer |
| nzcv_o | output | 4 | Condition nibble; Z in bit 2 |
| flag_invalid_o | output | 1 | Sticky invalid flag |
| flag_inexact_o | output | 1 | Sticky inexact flag |
| flag_denorm_o | output | 1 | Sticky denormal-input flag |

## Verification
Every result, the condition nibble, the output strobe and the flag updates are due exactly one rising edge after the cycle that holds in_valid_i. The bench drives the strobe on a falling edge and reads the outputs on the next falling edge, which is half a period after the register stage has captured them. Hold behaviour is checked one and two cycles later. The effect of a clear is read on the falling edge that follows the clear cycle.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
    localparam int unsigned DBL_W   = 64;
    localparam int unsigned EXP_W   = 11;
    localparam int unsigned FRAC_W  = 52;
    localparam int unsigned INT_W   = 32;
    localparam int unsigned BIAS    = 1023;
    localparam int unsigned MANT_W  = FRAC_W + 1;
    localparam int unsigned SH_W    = EXP_W + 2;
    localparam int unsigned SHAMT_W = $clog2(DBL_W);

    typedef enum logic [1:0] {
        CLS_ZERO_EXP = 2'd0,
        CLS_SPECIAL  = 2'd1,
        CLS_NORMAL   = 2'd2
    } cls_e;

    typedef struct packed {
        logic             out_valid;
        logic [INT_W-1:0] result;
        logic             z;
        logic             inv;
        logic             inx;
        logic             den;
    } cvt_state_t;
endpackage

// File: rtl/cvt_classify.sv
module cvt_classify
    import cvt_pkg::*;
(
    input  logic [DBL_W-1:0]  operand_i,
    output logic              sign_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic [FRAC_W-1:0] frac_o,
    output cls_e              cls_o
);
    always_comb begin
        sign_o = operand_i[DBL_W-1];
        exp_o  = operand_i[DBL_W-2 -: EXP_W];
        frac_o = operand_i[FRAC_W-1:0];
        if (exp_o == '0) begin
            cls_o = CLS_ZERO_EXP;
        end else if (exp_o == '1) begin
            cls_o = CLS_SPECIAL;
        end else begin
            cls_o = CLS_NORMAL;
        end
    end
endmodule

// File: rtl/cvt_align.sv
module cvt_align
    import cvt_pkg::*;
(
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic [DBL_W-1:0]  mag_o,
    output logic              lost_o,
    output logic              big_exp_o
);
    localparam logic signed [SH_W-1:0] SH_ZERO = SH_W'(BIAS + FRAC_W);
    localparam logic signed [SH_W-1:0] SH_LIM  = SH_W'(DBL_W);
    localparam logic [EXP_W-1:0]       EXP_TOP = EXP_W'(BIAS + INT_W - 1);

    logic signed [SH_W-1:0] sh;
    logic signed [SH_W-1:0] rsh;
    logic [DBL_W-1:0]       mant;
    logic [DBL_W-1:0]       mask;

    always_comb begin
        mant      = {{(DBL_W-MANT_W){1'b0}}, 1'b1, frac_i};
        sh        = $signed({2'b00, exp_i}) - SH_ZERO;
        rsh       = -sh;
        big_exp_o = exp_i > EXP_TOP;
        mag_o     = '0;
        lost_o    = 1'b0;
        mask      = '0;
        if (sh >= 0) begin
            if (sh < SH_LIM) begin
                mag_o = mant << sh[SHAMT_W-1:0];
            end
        end else if (rsh < SH_LIM) begin
            mask   = ~({DBL_W{1'b1}} << rsh[SHAMT_W-1:0]);
            mag_o  = mant >> rsh[SHAMT_W-1:0];
            lost_o = |(mant & mask);
        end else begin
            lost_o = 1'b1;
        end
    end
endmodule

// File: rtl/f64_modint32_cvt.sv
module f64_modint32_cvt
    import cvt_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              in_valid_i,
    input  logic [DBL_W-1:0]  operand_i,
    input  logic              flush_den_i,
    input  logic              clr_flags_i,
    output logic              out_valid_o,
    output logic [INT_W-1:0]  result_o,
    output logic [3:0]        nzcv_o,
    output logic              flag_invalid_o,
    output logic              flag_inexact_o,
    output logic              flag_denorm_o
);
    localparam logic [DBL_W-1:0] POS_LIM = (DBL_W'(1) << (INT_W-1)) - DBL_W'(1);
    localparam logic [DBL_W-1:0] NEG_LIM = DBL_W'(1) << (INT_W-1);

    logic              sign;
    logic [EXP_W-1:0]  expf;
    logic [FRAC_W-1:0] frac;
    cls_e              cls;
    logic [DBL_W-1:0]  mag;
    logic              lost;
    logic              big_exp;
    logic              ovf;
    cvt_state_t        st_d, st_q;

    cvt_classify u_cls (
        .operand_i (operand_i),
        .sign_o    (sign),
        .exp_o     (expf),
        .frac_o    (frac),
        .cls_o     (cls)
    );

    cvt_align u_aln (
        .exp_i     (expf),
        .frac_i    (frac),
        .mag_o     (mag),
        .lost_o    (lost),
        .big_exp_o (big_exp)
    );

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = in_valid_i;
        ovf            = big_exp || (mag > (sign ? NEG_LIM : POS_LIM));
        if (clr_flags_i) begin
            st_d.inv = 1'b0;
            st_d.inx = 1'b0;
            st_d.den = 1'b0;
        end
        if (in_valid_i) begin
            unique case (cls)
                CLS_ZERO_EXP: begin
                    st_d.result = '0;
                    st_d.z      = ~sign;
                    if (frac != '0) begin
                        if (flush_den_i) begin
                            st_d.den = 1'b1;
                        end else begin
                            st_d.inx = 1'b1;
                            st_d.z   = 1'b0;
                        end
                    end
                end
                CLS_SPECIAL: begin
                    st_d.result = '0;
                    st_d.z      = 1'b0;
                    st_d.inv    = 1'b1;
                end
                default: begin
                    st_d.result = sign ? (INT_W'(0) - mag[INT_W-1:0]) : mag[INT_W-1:0];
                    st_d.z      = ~(ovf | lost);
                    if (ovf) begin
                        st_d.inv = 1'b1;
                    end else if (lost) begin
                        st_d.inx = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o    = st_q.out_valid;
    assign result_o       = st_q.result;
    assign nzcv_o         = {1'b0, st_q.z, 2'b00};
    assign flag_invalid_o = st_q.inv;
    assign flag_inexact_o = st_q.inx;
    assign flag_denorm_o  = st_q.den;
endmodule

// File: rtl/cvt_modint32_chk.sv
module cvt_modint32_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        in_valid_i,
    input logic [63:0] operand_i,
    input logic        flush_den_i,
    input logic        clr_flags_i,
    input logic        out_valid_o,
    input logic [31:0] result_o,
    input logic [3:0]  nzcv_o,
    input logic        flag_invalid_o,
    input logic        flag_inexact_o,
    input logic        flag_denorm_o
);
    // R9
    strobe_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> out_valid_o);
    // R9
    strobe_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> (!out_valid_o && $stable(result_o) && $stable(nzcv_o)));
    // R8
    nibble_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (nzcv_o[3] == 1'b0) && (nzcv_o[1:0] == 2'b00));
    // R4
    special_exp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && operand_i[62:52] == 11'h7ff)
        |=> (result_o == 32'd0 && flag_invalid_o && nzcv_o == 4'd0));
    // R1
    zero_exp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && operand_i[62:52] == 11'd0) |=> (result_o == 32'd0));
    // R2
    flush_den_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && flush_den_i && operand_i[62:52] == 11'd0 && operand_i[51:0] != 52'd0)
        |=> (flag_denorm_o && nzcv_o[2] == !$past(operand_i[63])));
    // R10
    sticky_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_flags_i && flag_invalid_o) |=> flag_invalid_o);
    // R10
    clear_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_flags_i && !in_valid_i) |=> (!flag_invalid_o && !flag_inexact_o && !flag_denorm_o));
    // R5
    exact_no_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && nzcv_o[2]) |-> (!$rose(flag_invalid_o) && !$rose(flag_inexact_o)));
endmodule

bind f64_modint32_cvt cvt_modint32_chk u_chk (.*);

// File: tb/f64_modint32_cvt_tb.sv
`timescale 1ns/1ps
module f64_modint32_cvt_tb;
    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] operand = '0;
    logic        flush = 1'b0;
    logic        clr = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic [3:0]  nzcv;
    logic        f_inv, f_inx, f_den;

    int tests = 0;
    int fails = 0;
    logic [2:0] mflags = '0;

    always #2.5 clk = ~clk;

    f64_modint32_cvt u_dut (
        .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .operand_i(operand),
        .flush_den_i(flush), .clr_flags_i(clr), .out_valid_o(out_valid),
        .result_o(result), .nzcv_o(nzcv), .flag_invalid_o(f_inv),
        .flag_inexact_o(f_inx), .flag_denorm_o(f_den)
    );

    // returns {result, z, invalid, inexact, denorm}
    function automatic logic [35:0] model(input logic [63:0] op, input logic fl);
        logic        s;
        int          e;
        logic [63:0] fr, mant, mag;
        logic        z, inv, inx, den, lost, ovf;
        int          sh;
        logic [31:0] r;
        s = op[63]; e = int'(op[62:52]); fr = {12'd0, op[51:0]};
        z = 0; inv = 0; inx = 0; den = 0; r = 0;
        if (e == 0) begin
            z = !s;
            if (fr != 0) begin
                if (fl) den = 1;
                else begin inx = 1; z = 0; end
            end
        end else if (e == 2047) begin
            inv = 1;
        end else begin
            mant = fr | (64'd1 << 52);
            sh = e - 1075;
            lost = 0;
            if (sh >= 64) mag = 0;
            else if (sh >= 0) mag = mant << sh;
            else if (-sh >= 64) begin mag = 0; lost = 1; end
            else begin
                mag = mant >> (-sh);
                lost = ((mag << (-sh)) != mant);
            end
            ovf = (e - 1023 > 31) || (s ? (mag > 64'h8000_0000) : (mag > 64'h7fff_ffff));
            if (ovf) inv = 1;
            else if (lost) inx = 1;
            z = !ovf && !lost;
            r = s ? (32'd0 - mag[31:0]) : mag[31:0];
        end
        return {r, z, inv, inx, den};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic conv(input logic [63:0] op, input logic fl, input logic c, input string req);
        logic [35:0] m;
        m = model(op, fl);
        @(negedge clk);
        in_valid = 1; operand = op; flush = fl; clr = c;
        mflags = (c ? 3'b000 : mflags) | m[2:0];
        @(negedge clk);
        in_valid = 0; clr = 0;
        check({req, " R9 strobe"}, {31'd0, out_valid}, 32'd1);
        check({req, " result"}, result, m[35:4]);
        check({req, " R8 nzcv"}, {28'd0, nzcv}, {28'd0, 1'b0, m[3], 2'b00});
        check({req, " R10 flags"}, {29'd0, f_inv, f_inx, f_den}, {29'd0, mflags});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 reset outputs", {out_valid, nzcv, f_inv, f_inx, f_den}, 32'd0);
        check("R11 reset result", result, 32'd0);
        rst_ni = 1;
        @(negedge clk);

        conv(64'h0000_0000_0000_0000, 0, 0, "R1 +0");
        conv(64'h8000_0000_0000_0000, 0, 0, "R1 -0");
        conv(64'h0000_0000_0000_0001, 1, 0, "R2 +sub flush");
        conv(64'h800F_FFFF_FFFF_FFFF, 1, 1, "R2 -sub flush");
        conv(64'h0008_0000_0000_0000, 0, 1, "R3 +sub noflush");
        conv(64'h8000_0000_0000_0003, 0, 1, "R3 -sub noflush");
        conv(64'h7FF0_0000_0000_0000, 0, 1, "R4 +inf");
        conv(64'hFFF0_0000_0000_0000, 0, 1, "R4 -inf");
        conv(64'h7FF8_0000_0000_0001, 1, 1, "R4 nan");
        conv(64'h3FF0_0000_0000_0000, 0, 1, "R5 one");
        conv(64'hBFF8_0000_0000_0000, 0, 1, "R5 -1.5");
        conv(64'h3FE0_0000_0000_0000, 0, 1, "R5 half");
        conv(64'h0010_0000_0000_0000, 0, 1, "R7 tiny normal");
        conv(64'h41DF_FFFF_FFC0_0000, 0, 1, "R5 max pos");
        conv(64'hC1E0_0000_0000_0000, 0, 1, "R6 -2^31 exact");
        conv(64'h41E0_0000_0000_0000, 0, 1, "R6 +2^31 ovf");
        conv(64'hC1E0_0000_0020_0000, 0, 1, "R6 below -2^31");
        conv(64'h41F0_0000_0050_0000, 0, 1, "R7 2^32+5 wrap");
        conv(64'h4330_0000_0000_0001, 0, 1, "R7 2^52+1");
        conv(64'hC3B0_0000_0000_0001, 0, 1, "R7 -big shifted");
        conv(64'h4730_0000_0000_0000, 0, 1, "R7 shift 64");

        // R9 hold after strobe
        conv(64'h4059_0000_0000_0000, 0, 1, "R9 hundred");
        held = result;
        @(negedge clk);
        check("R9 hold result", result, held);
        check("R9 strobe low", {31'd0, out_valid}, 32'd0);

        // R10 sticky accumulation and standalone clear
        conv(64'h3FF8_0000_0000_0000, 0, 1, "R10 inexact");
        conv(64'h7FF0_0000_0000_0000, 0, 0, "R10 add invalid");
        conv(64'h3FF0_0000_0000_0000, 0, 0, "R10 keep");
        @(negedge clk); clr = 1;
        @(negedge clk); clr = 0; mflags = '0;
        check("R10 cleared", {29'd0, f_inv, f_inx, f_den}, 32'd0);

        for (int i = 0; i < 400; i++) begin
            logic [63:0] op;
            op = {$urandom, $urandom};
            if (i % 3 != 0) op[62:52] = 11'($urandom_range(1000, 1090));
            if (i % 17 == 0) op[62:52] = 11'd0;
            conv(op, 1'($urandom), 1'(i % 5 == 0), "R5 R6 R7 random");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule